// File: doc/BRIEF.md
# Bit-Sliced Integer ALU with Signed Set-Less-Than

This block is a purely combinational integer ALU built as a row of identical one-bit slices. Each slice computes four candidate outputs at the same time: the AND of its two operand bits, their OR, a full-adder sum, and a pass-through of a one-bit "less" input. A 2-bit operation code then picks one of the four. A single operand-inversion control feeds the second operand through an inverter in every slice. The same control also supplies the carry into bit 0. With it, one adder performs both addition and two's-complement subtraction.

The most significant slice also produces the signed overflow indication and a "set" bit. The set bit is the sign of A−B, corrected for overflow. It is routed back into the less input of bit 0, and every other slice's less input is tied low. So operation code 11 combined with inversion yields 1 when A is less than B as signed numbers, and 0 otherwise. A zero flag is the NOR of every result bit. A datapath can therefore test equality by subtracting and examining the zero flag.

Top module: `bsalu_top`

## Requirements
- R1: With b_inv=0 and op_sel=00, result equals a_in AND b_in.
- R2: With b_inv=0 and op_sel=01, result equals a_in OR b_in.
- R3: With b_inv=0 and op_sel=10, {carry_out, result} equals the 33-bit unsigned sum a_in + b_in.
- R4: With b_inv=1 and op_sel=10, result equals a_in − b_in modulo 2^32. In this case carry_out is 1 exactly when a_in ≥ b_in as unsigned numbers.
- R5: With b_inv=1 and op_sel=11, result bit 0 is 1 exactly when a_in < b_in as signed two's-complement numbers. Result bits 31..1 are always 0 under op_sel=11. The result stays correct when a_in − b_in overflows.
- R6: zero is 1 exactly when every bit of result is 0, for every operation.
- R7: With op_sel=10, overflow is 1 exactly when the signed sum or difference selected by b_inv does not fit in 32 bits. For every other op_sel, overflow is 0.
- R8: With b_inv=1, the logical operations use the inverted second operand: op_sel=00 gives a_in AND NOT b_in, and op_sel=01 gives a_in OR NOT b_in.
- R9: Under every op_sel, carry_out equals bit 32 of a_in + (b_inv ? NOT b_in : b_in) + b_inv.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_in | input | 32 | First operand |
| b_in | input | 32 | Second operand |
| b_inv | input | 1 | Inverts the second operand and sets the carry into bit 0 |
| op_sel | input | 2 | Slice output select: 00 AND, 01 OR, 10 adder, 11 less |
| result | output | 32 | Selected result word |
| zero | output | 1 | 1 when result is all zeros |
| overflow | output | 1 | Signed overflow of the add/subtract (op_sel=10 only) |
| carry_out | output | 1 | Carry out of the most significant slice |

## Verification
The bench targets operands at the signed and unsigned extremes: 0, all ones, the most negative value and the most positive value, in every pairing. At these values a design that takes the raw sign bit instead of the corrected one gets the set-less-than answer backwards, for example when comparing the most negative value with a positive one. The same pairings catch an adder without the carry-in of one, which is off by one on every subtraction, and an overflow term taken from the wrong carries, which flags sums that do not overflow or misses the ones that do. Further cases check that the inverted operand reaches the logical operations, that overflow stays quiet outside the adder operation, and that the zero flag tracks results that cancel to zero under subtraction.

// File: rtl/bsalu_pkg.sv
package bsalu_pkg;

  typedef enum logic [1:0] {
    OP_AND  = 2'b00,
    OP_OR   = 2'b01,
    OP_ADD  = 2'b10,
    OP_LESS = 2'b11
  } op_e;

  function automatic logic fa_sum(input logic x, input logic y, input logic c);
    return x ^ y ^ c;
  endfunction

  function automatic logic fa_carry(input logic x, input logic y, input logic c);
    return (x & y) | (x & c) | (y & c);
  endfunction

  function automatic logic slice_pick(input op_e op, input logic and_v,
                                      input logic or_v, input logic sum_v,
                                      input logic less_v);
    logic r;
    case (op)
      OP_AND:  r = and_v;
      OP_OR:   r = or_v;
      OP_ADD:  r = sum_v;
      default: r = less_v;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/bsalu_slice.sv
module bsalu_slice
  import bsalu_pkg::*;
(
  input  logic       a_bit,
  input  logic       b_bit,
  input  logic       b_inv,
  input  logic       carry_in,
  input  logic       less_in,
  input  logic [1:0] op,
  output logic       res_bit,
  output logic       carry_out
);
  logic b_eff;
  logic and_v, or_v, sum_v;

  assign b_eff     = b_bit ^ b_inv;
  assign and_v     = a_bit & b_eff;
  assign or_v      = a_bit | b_eff;
  assign sum_v     = fa_sum(a_bit, b_eff, carry_in);
  assign carry_out = fa_carry(a_bit, b_eff, carry_in);
  assign res_bit   = slice_pick(op_e'(op), and_v, or_v, sum_v, less_in);
endmodule

// File: rtl/bsalu_msb_slice.sv
module bsalu_msb_slice
  import bsalu_pkg::*;
(
  input  logic       a_bit,
  input  logic       b_bit,
  input  logic       b_inv,
  input  logic       carry_in,
  input  logic       less_in,
  input  logic [1:0] op,
  output logic       res_bit,
  output logic       carry_out,
  output logic       set_out,
  output logic       ovf_out
);
  logic sign_raw;

  bsalu_slice u_core (
    .a_bit    (a_bit),
    .b_bit    (b_bit),
    .b_inv    (b_inv),
    .carry_in (carry_in),
    .less_in  (less_in),
    .op       (op),
    .res_bit  (res_bit),
    .carry_out(carry_out)
  );

  // sign of the adder output, recomputed here for the compare path
  assign sign_raw = fa_sum(a_bit, b_bit ^ b_inv, carry_in);
  assign ovf_out  = carry_in ^ carry_out;
  assign set_out  = sign_raw ^ ovf_out;
endmodule

// File: rtl/bsalu_zero.sv
module bsalu_zero #(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] value,
  output logic             is_zero
);
  assign is_zero = ~|value;
endmodule

// File: rtl/bsalu_top.sv
module bsalu_top
  import bsalu_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] a_in,
  input  logic [WIDTH-1:0] b_in,
  input  logic             b_inv,
  input  logic [1:0]       op_sel,
  output logic [WIDTH-1:0] result,
  output logic             zero,
  output logic             overflow,
  output logic             carry_out
);
  localparam int MSB = WIDTH - 1;

  logic [WIDTH:0] carry;
  logic           set_less;
  logic           ovf_raw;

  assign carry[0] = b_inv;

  generate
    for (genvar i = 0; i < MSB; i++) begin : g_lo
      bsalu_slice u_slice (
        .a_bit    (a_in[i]),
        .b_bit    (b_in[i]),
        .b_inv    (b_inv),
        .carry_in (carry[i]),
        .less_in  ((i == 0) ? set_less : 1'b0),
        .op       (op_sel),
        .res_bit  (result[i]),
        .carry_out(carry[i+1])
      );
    end
  endgenerate

  bsalu_msb_slice u_msb (
    .a_bit    (a_in[MSB]),
    .b_bit    (b_in[MSB]),
    .b_inv    (b_inv),
    .carry_in (carry[MSB]),
    .less_in  (1'b0),
    .op       (op_sel),
    .res_bit  (result[MSB]),
    .carry_out(carry[WIDTH]),
    .set_out  (set_less),
    .ovf_out  (ovf_raw)
  );

  bsalu_zero #(.WIDTH(WIDTH)) u_zero (
    .value  (result),
    .is_zero(zero)
  );

  assign carry_out = carry[WIDTH];
  assign overflow  = (op_e'(op_sel) == OP_ADD) & ovf_raw;

  always_comb begin
    a_r6_zero_flag: assert (zero == (result == '0));
    if (op_sel != 2'b10) begin
      a_r7_ovf_quiet: assert (!overflow);
    end
    if (op_sel == 2'b11) begin
      a_r5_upper_clear: assert (result[MSB:1] == '0);
    end
    if (op_sel == 2'b10 && !b_inv) begin
      a_r3_add_sum: assert ({carry_out, result} == ({1'b0, a_in} + {1'b0, b_in}));
    end
    if (op_sel == 2'b10 && b_inv) begin
      a_r4_sub_diff: assert (result == a_in - b_in);
    end
  end
endmodule

// File: tb/bsalu_top_test.sv
module bsalu_top_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] a_in = '0, b_in = '0;
  logic        b_inv = 1'b0;
  logic [1:0]  op_sel = 2'b00;
  logic [31:0] result;
  logic        zero, overflow, carry_out;
  int          n_checks = 0, n_fail = 0;

  typedef struct {
    logic [31:0] exp_res;
    logic        exp_z, exp_o, exp_c;
    string       tag, ctag;
  } item_t;
  item_t q[$];

  always #5 clk = ~clk;

  bsalu_top uut (
    .a_in(a_in), .b_in(b_in), .b_inv(b_inv), .op_sel(op_sel),
    .result(result), .zero(zero), .overflow(overflow), .carry_out(carry_out)
  );

  task automatic chk(input logic ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic drive(input logic [31:0] a, input logic [31:0] b,
                       input logic inv, input logic [1:0] op);
    item_t it;
    logic [31:0] bb;
    logic [32:0] wide;
    longint sa, sb, sf;
    bb   = inv ? ~b : b;
    wide = {1'b0, a} + {1'b0, bb} + {32'd0, inv};
    sa = longint'($signed(a));
    sb = longint'($signed(b));
    sf = inv ? sa - sb : sa + sb;
    case (op)
      2'b00: begin it.exp_res = a & bb; it.tag = inv ? "R8" : "R1"; end
      2'b01: begin it.exp_res = a | bb; it.tag = inv ? "R8" : "R2"; end
      2'b10: begin it.exp_res = wide[31:0]; it.tag = inv ? "R4" : "R3"; end
      default: begin
        it.exp_res = {31'd0, ($signed(a) < $signed(b))};
        it.tag = "R5";
      end
    endcase
    it.exp_z = (it.exp_res == 32'd0);
    it.exp_o = (op == 2'b10) && (sf > 64'sd2147483647 || sf < -64'sd2147483648);
    it.exp_c = wide[32];
    it.ctag  = (op == 2'b10) ? it.tag : "R9";
    @(posedge clk);
    a_in = a; b_in = b; b_inv = inv; op_sel = op;
    q.push_back(it);
  endtask

  always @(negedge clk) begin
    if (q.size() > 0) begin
      item_t it;
      it = q.pop_front();
      chk(result == it.exp_res, it.tag, "result", result, it.exp_res);
      chk(zero == it.exp_z, "R6", "zero", {31'd0, zero}, {31'd0, it.exp_z});
      chk(overflow == it.exp_o, "R7", "overflow", {31'd0, overflow}, {31'd0, it.exp_o});
      chk(carry_out == it.exp_c, it.ctag, "carry_out", {31'd0, carry_out}, {31'd0, it.exp_c});
    end
  end

  task automatic summary;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
  endtask

  initial begin
    logic [31:0] corner [5];
    corner[0] = 32'h0000_0000; corner[1] = 32'hFFFF_FFFF;
    corner[2] = 32'h8000_0000; corner[3] = 32'h7FFF_FFFF;
    corner[4] = 32'h0000_0001;
    fork
      begin
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        // state after reset with all-zero inputs: R6 zero flag high
        drive(32'd0, 32'd0, 1'b0, 2'b00);
        for (int i = 0; i < 5; i++)
          for (int j = 0; j < 5; j++) begin
            drive(corner[i], corner[j], 1'b0, 2'b00);
            drive(corner[i], corner[j], 1'b0, 2'b01);
            drive(corner[i], corner[j], 1'b0, 2'b10);
            drive(corner[i], corner[j], 1'b1, 2'b10);
            drive(corner[i], corner[j], 1'b1, 2'b11);
            drive(corner[i], corner[j], 1'b1, 2'b00);
            drive(corner[i], corner[j], 1'b1, 2'b01);
          end
        for (int k = 0; k < 400; k++) begin
          logic [31:0] ra, rb;
          ra = $urandom();
          rb = (k % 4 == 0) ? corner[k % 5] : $urandom();
          if (k % 8 == 1) rb = ra;   // R4/R6: equal operands cancel to zero
          drive(ra, rb, 1'b0, 2'b00);
          drive(ra, rb, 1'b0, 2'b01);
          drive(ra, rb, 1'b0, 2'b10);
          drive(ra, rb, 1'b1, 2'b10);
          drive(ra, rb, 1'b1, 2'b11);
          drive(ra, rb, k[0], 2'(k % 2));
        end
        @(posedge clk);
        wait (q.size() == 0);
        @(posedge clk);
      end
      begin
        repeat (200000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    summary();
    $finish;
  end
endmodule